// File: doc/BRIEF.md
# Saturating 40-bit Arithmetic and Logic Unit

This unit is one execution slot of a signal-processing datapath. Each cycle it may accept one operation: a 4-bit opcode, two 40-bit operand buses and a qualifying valid strobe. One cycle later it presents a 40-bit result. It adds and subtracts at 32-bit width, with or without clamping. It adds and subtracts at 40-bit accumulator width with clamping. It also covers saturating absolute value, packed arithmetic on two independent 16-bit lanes, signed and unsigned compares, and bitwise AND, OR and XOR.

The unit has no carry or overflow flags. Its single status output is a sticky saturation bit. Any clamping operation sets it, and only an explicit clear input drops it. Software can therefore run a long kernel and test afterwards whether precision was lost anywhere. Operations that use only 32 bits take the low 32 bits of each operand bus.

Top module: `sat_alu40`

## Requirements
- R1: Opcode 0 gives the low 32 bits of A plus B, and opcode 1 gives A minus B, both wrapping modulo 2^32. The 32-bit result is sign-extended from bit 31 onto the 40-bit result bus.
- R2: Opcodes 2 (add) and 3 (subtract) operate on signed 32-bit values. A result above 0x7FFFFFFF is replaced by 0x7FFFFFFF, and a result below 0x80000000 by 0x80000000. The result is sign-extended to 40 bits.
- R3: Opcodes 4 (add) and 5 (subtract) operate on the full signed 40-bit operands. They clamp to 0x7FFFFFFFFF or 0x8000000000.
- R4: Packed opcodes treat bits 15:0 and 31:16 as two independent signed lanes, with no carry between them. Opcode 7 adds with wrap, opcode 8 adds with clamping and opcode 9 subtracts with clamping. Each lane clamps to 0x7FFF or 0x8000 on its own. The result is sign-extended from bit 31.
- R5: Opcode 6 returns the absolute value of signed 32-bit A, sign-extended. The input 0x80000000 returns 0x7FFFFFFF and counts as a clamp.
- R6: Compares put 1 or 0 in bit 0 and zero in every other bit. Opcode 10 tests A equal to B on the low 32 bits. Opcode 11 tests A greater than B as signed 32-bit values, and opcode 12 tests the same as unsigned values.
- R7: Opcodes 13, 14 and 15 return the bitwise AND, OR and XOR of all 40 operand bits.
- R8: The status bit rises in the cycle after an accepted operation clamps. Operations that do not clamp never set it, and the wrapping opcodes never clamp.
- R9: The status bit stays high until the clear input is asserted. The clear takes effect on the next edge. When a clamping operation and a clear arrive in the same cycle, the bit is set.
- R10: An operation accepted with valid high appears on the result bus one cycle later, with the output valid high. While input valid is low, the result bus holds its value, the output valid is low and the status bit is not set.
- R11: After reset, the result bus, the output valid and the status bit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Accepts the operation presented this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 40 | Operand A |
| b_i | input | 40 | Operand B |
| sat_clr_i | input | 1 | Clears the sticky saturation bit |
| res_o | output | 40 | Registered result |
| valid_o | output | 1 | Result bus carries a new result |
| sat_o | output | 1 | Sticky saturation status |

## Verification
The status bit can see a clamping operation and a clear in the same cycle. The bench provokes this by raising the clear alongside saturating adds at 32 bits, at 40 bits and in the packed lanes. It also pairs the clear with non-clamping operations and with idle cycles. In each case it compares the status bit after the edge against a model in which a new clamp outranks the clear. Directed extremes cover both lanes clamping in opposite directions and the absolute value of the most negative input. A long stream of random operations, each checked every cycle against a behavioural model, completes the run.

// File: rtl/sat_alu40_pkg.sv
package sat_alu40_pkg;

  typedef enum logic [3:0] {
    OP_ADD32  = 4'd0,
    OP_SUB32  = 4'd1,
    OP_SADD32 = 4'd2,
    OP_SSUB32 = 4'd3,
    OP_SADD40 = 4'd4,
    OP_SSUB40 = 4'd5,
    OP_ABS32  = 4'd6,
    OP_ADD2   = 4'd7,
    OP_SADD2  = 4'd8,
    OP_SSUB2  = 4'd9,
    OP_CMPEQ  = 4'd10,
    OP_CMPGT  = 4'd11,
    OP_CMPGTU = 4'd12,
    OP_AND    = 4'd13,
    OP_OR     = 4'd14,
    OP_XOR    = 4'd15
  } alu_op_e;

endpackage

// File: rtl/alu_addsub_sat.sv
module alu_addsub_sat #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] wrap,
  output logic [W-1:0] clamped,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;

  always_comb begin
    b_eff   = sub ? ~b : b;
    wrap    = a + b_eff + {{(W-1){1'b0}}, sub};
    ovf     = (a[W-1] == b_eff[W-1]) && (wrap[W-1] != a[W-1]);
    clamped = ovf ? (a[W-1] ? MINV : MAXV) : wrap;
  end

  always_comb begin
    if (!$isunknown({a, b, sub})) begin
      AST_CLAMP_EXTREME: assert (!ovf || clamped == MAXV || clamped == MINV); // R2
    end
  end

endmodule

// File: rtl/alu_cmp_logic.sv
module alu_cmp_logic #(
  parameter int WW = 40,
  parameter int NW = 32
) (
  input  logic [3:0]    op,
  input  logic [WW-1:0] a,
  input  logic [WW-1:0] b,
  output logic [WW-1:0] res
);
  import sat_alu40_pkg::*;

  logic eq, gt_s, gt_u;

  always_comb begin
    eq   = (a[NW-1:0] == b[NW-1:0]);
    gt_u = (a[NW-1:0] > b[NW-1:0]);
    gt_s = ($signed(a[NW-1:0]) > $signed(b[NW-1:0]));
    res  = '0;
    case (alu_op_e'(op))
      OP_CMPEQ:  res[0] = eq;
      OP_CMPGT:  res[0] = gt_s;
      OP_CMPGTU: res[0] = gt_u;
      OP_AND:    res = a & b;
      OP_OR:     res = a | b;
      OP_XOR:    res = a ^ b;
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/sat_alu40.sv
module sat_alu40 #(
  parameter int WW = 40,
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  input  logic [3:0]    op_i,
  input  logic [WW-1:0] a_i,
  input  logic [WW-1:0] b_i,
  input  logic          sat_clr_i,
  output logic [WW-1:0] res_o,
  output logic          valid_o,
  output logic          sat_o
);
  import sat_alu40_pkg::*;

  localparam int HW    = NW / 2;
  localparam int LANES = 2;
  localparam int XW    = WW - NW;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [NW-1:0] w32, c32, abs_neg, abs_c;
  logic          o32, abs_ovf;
  logic [WW-1:0] w40, c40, cl_res;
  logic          o40;
  logic [HW-1:0] lw [LANES];
  logic [HW-1:0] lc [LANES];
  logic [LANES-1:0] lo;
  logic [NW-1:0] pk_wrap, pk_sat;

  logic          sub32, sub40, subp;
  assign sub32 = (op == OP_SUB32) || (op == OP_SSUB32);
  assign sub40 = (op == OP_SSUB40);
  assign subp  = (op == OP_SSUB2);

  alu_addsub_sat #(.W(NW)) u_add32 (
    .a(a_i[NW-1:0]), .b(b_i[NW-1:0]), .sub(sub32),
    .wrap(w32), .clamped(c32), .ovf(o32)
  );

  alu_addsub_sat #(.W(WW)) u_add40 (
    .a(a_i), .b(b_i), .sub(sub40),
    .wrap(w40), .clamped(c40), .ovf(o40)
  );

  alu_addsub_sat #(.W(NW)) u_neg32 (
    .a('0), .b(a_i[NW-1:0]), .sub(1'b1),
    .wrap(abs_neg), .clamped(abs_c), .ovf(abs_ovf)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    alu_addsub_sat #(.W(HW)) u_lane (
      .a(a_i[l*HW +: HW]), .b(b_i[l*HW +: HW]), .sub(subp),
      .wrap(lw[l]), .clamped(lc[l]), .ovf(lo[l])
    );
    assign pk_wrap[l*HW +: HW] = lw[l];
    assign pk_sat[l*HW +: HW]  = lc[l];
  end

  alu_cmp_logic #(.WW(WW), .NW(NW)) u_cmp (
    .op(op_i), .a(a_i), .b(b_i), .res(cl_res)
  );

  function automatic logic [WW-1:0] sx(input logic [NW-1:0] v);
    return {{XW{v[NW-1]}}, v};
  endfunction

  logic [WW-1:0] res_d, res_q;
  logic          clamp, sat_d, sat_q, vld_q;

  always_comb begin
    clamp = 1'b0;
    case (op)
      OP_ADD32, OP_SUB32:   res_d = sx(w32);
      OP_SADD32, OP_SSUB32: begin res_d = sx(c32); clamp = o32; end
      OP_SADD40, OP_SSUB40: begin res_d = c40;     clamp = o40; end
      OP_ABS32: begin
        res_d = a_i[NW-1] ? sx(abs_c) : sx(a_i[NW-1:0]);
        clamp = a_i[NW-1] & abs_ovf;
      end
      OP_ADD2:              res_d = sx(pk_wrap);
      OP_SADD2, OP_SSUB2:   begin res_d = sx(pk_sat); clamp = |lo; end
      default:              res_d = cl_res;
    endcase
    sat_d = (in_valid_i & clamp) | (sat_q & ~sat_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      vld_q <= in_valid_i;
      sat_q <= sat_d;
      if (in_valid_i) res_q <= res_d;
    end
  end

  assign res_o   = res_q;
  assign valid_o = vld_q;
  assign sat_o   = sat_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_o && !sat_clr_i) |=> sat_o); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr_i && !in_valid_i) |=> !sat_o); // R9
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> valid_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!valid_o && $stable(res_o))); // R10
  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i >= 4'd10 && op_i <= 4'd12) |=> (res_o[WW-1:1] == '0)); // R6
  AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 4'd6) |=> !res_o[NW-1]); // R5

endmodule

// File: tb/sat_alu40_bench.sv
module sat_alu40_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [39:0] a_i = '0;
  logic [39:0] b_i = '0;
  logic        sat_clr_i = 1'b0;
  logic [39:0] res_o;
  logic        valid_o, sat_o;

  always #4 clk = ~clk;

  sat_alu40 u_sat_alu40 (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .sat_clr_i(sat_clr_i),
    .res_o(res_o), .valid_o(valid_o), .sat_o(sat_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [39:0] exp_res = '0;
  logic        exp_vld = 1'b0;
  logic        exp_sat = 1'b0;

  localparam longint MAX32 = 64'sd2147483647;
  localparam longint MIN32 = -64'sd2147483648;
  localparam longint MAX40 = 64'sd549755813887;
  localparam longint MIN40 = -64'sd549755813888;

  function automatic logic [39:0] sx(input logic [31:0] v);
    return {{8{v[31]}}, v};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4, 4'd5: return "R3";
      4'd6:       return "R5";
      4'd7, 4'd8, 4'd9: return "R4";
      4'd10, 4'd11, 4'd12: return "R6";
      default:    return "R7";
    endcase
  endfunction

  // Behavioural model: returns result and whether it clamped
  task automatic model(input logic [3:0] op, input logic [39:0] a, input logic [39:0] b,
                       output logic [39:0] r, output logic cl);
    longint s, x, y;
    r = '0; cl = 1'b0;
    case (op)
      4'd0: r = sx(a[31:0] + b[31:0]);
      4'd1: r = sx(a[31:0] - b[31:0]);
      4'd2, 4'd3: begin
        x = longint'($signed(a[31:0])); y = longint'($signed(b[31:0]));
        s = (op == 4'd2) ? x + y : x - y;
        if (s > MAX32) begin s = MAX32; cl = 1; end
        if (s < MIN32) begin s = MIN32; cl = 1; end
        r = sx(s[31:0]);
      end
      4'd4, 4'd5: begin
        x = longint'($signed(a)); y = longint'($signed(b));
        s = (op == 4'd4) ? x + y : x - y;
        if (s > MAX40) begin s = MAX40; cl = 1; end
        if (s < MIN40) begin s = MIN40; cl = 1; end
        r = s[39:0];
      end
      4'd6: begin
        x = longint'($signed(a[31:0]));
        s = (x < 0) ? -x : x;
        if (s > MAX32) begin s = MAX32; cl = 1; end
        r = sx(s[31:0]);
      end
      4'd7, 4'd8, 4'd9: begin
        logic [31:0] p;
        for (int h = 0; h < 2; h++) begin
          x = longint'($signed(a[16*h +: 16])); y = longint'($signed(b[16*h +: 16]));
          s = (op == 4'd9) ? x - y : x + y;
          if (op != 4'd7) begin
            if (s > 32767)  begin s = 32767;  cl = 1; end
            if (s < -32768) begin s = -32768; cl = 1; end
          end
          p[16*h +: 16] = s[15:0];
        end
        r = sx(p);
      end
      4'd10: r = {39'd0, a[31:0] == b[31:0]};
      4'd11: r = {39'd0, $signed(a[31:0]) > $signed(b[31:0])};
      4'd12: r = {39'd0, a[31:0] > b[31:0]};
      4'd13: r = a & b;
      4'd14: r = a | b;
      default: r = a ^ b;
    endcase
  endtask

  task automatic check(input string tag);
    vectors++;
    if (res_o !== exp_res || valid_o !== exp_vld || sat_o !== exp_sat) begin
      miscompares++;
      $display("FAIL %s: res=%h vld=%b sat=%b expected res=%h vld=%b sat=%b",
               tag, res_o, valid_o, sat_o, exp_res, exp_vld, exp_sat);
    end
  endtask

  // Drives one cycle at the falling edge; compares at the next falling edge
  task automatic apply(input logic v, input logic [3:0] op, input logic [39:0] a,
                       input logic [39:0] b, input logic clr, input string tag);
    logic [39:0] r;
    logic cl;
    in_valid_i = v; op_i = op; a_i = a; b_i = b; sat_clr_i = clr;
    model(op, a, b, r, cl);
    exp_sat = (v & cl) | (exp_sat & ~clr);
    exp_vld = v;
    if (v) exp_res = r;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11");

    // R1 wrap, no clamp, no status
    apply(1, 4'd0, 40'h00_7FFFFFFF, 40'h00_00000001, 0, "R1");
    apply(1, 4'd1, 40'h00_00000000, 40'h00_00000001, 0, "R1");
    // R2 32-bit clamps, sets sticky (R8)
    apply(1, 4'd2, 40'h00_7FFFFFFF, 40'h00_00000001, 0, "R2");
    apply(1, 4'd0, 40'h00_00000001, 40'h00_00000001, 0, "R9");
    apply(0, 4'd0, 40'h0, 40'h0, 1, "R9");
    apply(1, 4'd3, 40'h00_80000000, 40'h00_00000001, 0, "R2");
    apply(1, 4'd2, 40'h00_00000005, 40'h00_FFFFFFFE, 1, "R9");
    // R3 40-bit clamps
    apply(1, 4'd4, 40'h7F_FFFFFFFF, 40'h00_00000001, 0, "R3");
    apply(1, 4'd5, 40'h80_00000000, 40'h00_00000001, 0, "R3");
    apply(1, 4'd4, 40'h00_FFFFFFFF, 40'h00_00000001, 1, "R8");
    // Clamp and clear in same cycle: set wins
    apply(1, 4'd4, 40'h7F_00000000, 40'h7F_00000000, 1, "R9");
    apply(0, 4'd0, 40'h0, 40'h0, 1, "R9");
    // R4 packed lanes: opposite-direction clamps, no carry across
    apply(1, 4'd8, 40'h00_80007FFF, 40'h00_80000001, 0, "R4");
    apply(0, 4'd0, 40'h0, 40'h0, 1, "R4");
    apply(1, 4'd7, 40'h00_0000FFFF, 40'h00_00000001, 0, "R4");
    apply(1, 4'd9, 40'h00_7FFF8000, 40'h00_FFFF0001, 1, "R4");
    apply(0, 4'd0, 40'h0, 40'h0, 1, "R9");
    // R5 abs
    apply(1, 4'd6, 40'h00_FFFFFFFB, 40'h0, 0, "R5");
    apply(1, 4'd6, 40'h00_80000000, 40'h0, 0, "R5");
    apply(0, 4'd0, 40'h0, 40'h0, 1, "R9");
    // R6 compares
    apply(1, 4'd10, 40'hAB_12345678, 40'h00_12345678, 0, "R6");
    apply(1, 4'd11, 40'h00_FFFFFFFF, 40'h00_00000001, 0, "R6");
    apply(1, 4'd12, 40'h00_FFFFFFFF, 40'h00_00000001, 0, "R6");
    // R7 logic
    apply(1, 4'd13, 40'hF0_F0F0F0F0, 40'hFF_00FF00FF, 0, "R7");
    apply(1, 4'd14, 40'hF0_F0F0F0F0, 40'h0F_00FF00FF, 0, "R7");
    apply(1, 4'd15, 40'hFF_FFFFFFFF, 40'hA5_5A5A5A5A, 0, "R7");
    // R10 idle with a clamping op on the bus: no effect
    apply(0, 4'd2, 40'h00_7FFFFFFF, 40'h00_7FFFFFFF, 0, "R10");
    apply(0, 4'd4, 40'h7F_FFFFFFFF, 40'h7F_FFFFFFFF, 0, "R10");

    // Random stream
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] op;
      logic [39:0] a, b;
      op = 4'($urandom_range(0, 15));
      a  = {8'($urandom), 32'($urandom)};
      b  = {8'($urandom), 32'($urandom)};
      if (($urandom & 7) == 0) a[31:0] = {1'b1, 31'd0};
      apply(($urandom & 7) != 0, op, a, b, ($urandom & 15) == 0, tag_of(op));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule